// File: doc/BRIEF.md
# Dual-Ratio Mode-Selectable Clock Divider

This block derives two related clock groups from one fast input clock. The primary group runs at the input rate divided by a ratio of 4, 5 or 6. The secondary group runs at exactly half the primary rate, which is the input divided by 8, 10 or 12. A two-bit select code chooses the ratio. One code value is reserved and keeps both groups idle.

A single phase counter drives both groups, so the edges of the two groups stay locked together. Every rising edge of the secondary output falls on the same input edge as a rising edge of the primary output. A one-cycle strobe marks that shared edge so that checkers downstream can sample it. The odd ratio gives the primary output a deliberate 40/60 duty cycle. The secondary output is always 50/50.

All outputs come straight from flip-flops clocked by the input clock. The divider restarts from a known phase after a synchronous reset and after any change of the select code.

Top module: `clk_ratio_div`

## Requirements
- R1: The primary output `prim_o` has a period of N input cycles, where N is set by `sel_i`: `2'b01` gives N=4, `2'b00` gives N=5, and `2'b10` gives N=6 (`sel_i[0]` is the low bit).
- R2: The secondary output `sec_o` has a period of 2N input cycles in every valid mode.
- R3: With N=5, `prim_o` is high for 2 input cycles and low for 3 in each period.
- R4: With N=4 or N=6, `prim_o` is high for N/2 input cycles and low for N/2.
- R5: `sec_o` is high for N input cycles and low for N input cycles in every valid mode, including N=5.
- R6: Every rising edge of `sec_o` happens on the same clock edge as a rising edge of `prim_o`. `align_o` is high for exactly the one cycle that follows such an edge, and it is low at all other times.
- R7: A clock edge with `rst_i` high drives all three outputs low. Counting restarts after the first edge with `rst_i` low: `prim_o` and `sec_o` both rise on that edge, and `align_o` is high in the cycle that follows it.
- R8: On an edge where `sel_i` differs from its value at the previous edge, all outputs go low. The next edge then restarts counting as in R7, using the new ratio.
- R9: While `sel_i` is `2'b11` (reserved), all outputs stay low. When a valid code is applied again, the restart rule of R8 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock; every output changes only on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | 2 | Ratio select: 01 gives /4, 00 gives /5, 10 gives /6, 11 is reserved |
| prim_o | output | 1 | Primary-group clock, input divided by N |
| sec_o | output | 1 | Secondary-group clock, input divided by 2N |
| align_o | output | 1 | One-cycle strobe after a shared rising edge of both groups |

## Verification
The assertions assume that `sel_i` and `rst_i` are synchronous to `clk_i` and settle well before each rising edge. They also assume that `rst_i` is high on the first edge, so the select register and the counter hold known values before any property is enabled. The bench changes every input only on the falling edge of the clock. It applies reset before anything else, and it changes the code both during long runs and in quick succession. This exercises the restart path without ever violating these assumptions.

// File: rtl/ckd_pkg.sv
package ckd_pkg;

  localparam int unsigned MAX_RATIO = 6;
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO + 1);

  typedef enum logic [1:0] {
    SEL_DIV5 = 2'b00,
    SEL_DIV4 = 2'b01,
    SEL_DIV6 = 2'b10,
    SEL_RSVD = 2'b11
  } sel_code_e;

  // Ratio selected by a code; 0 marks the reserved code.
  function automatic logic [CNT_W-1:0] ratio_of(input logic [1:0] code);
    case (sel_code_e'(code))
      SEL_DIV4: ratio_of = CNT_W'(4);
      SEL_DIV5: ratio_of = CNT_W'(5);
      SEL_DIV6: ratio_of = CNT_W'(6);
      default:  ratio_of = '0;
    endcase
  endfunction

  // High phase length: floor(N/2), which gives 2 high / 3 low for N=5.
  function automatic logic [CNT_W-1:0] high_of(input logic [CNT_W-1:0] ratio);
    high_of = ratio >> 1;
  endfunction

  function automatic logic is_reserved(input logic [1:0] code);
    is_reserved = (sel_code_e'(code) == SEL_RSVD);
  endfunction

endpackage

// File: rtl/ckd_mode_ctl.sv
module ckd_mode_ctl
  import ckd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [1:0]       sel_i,
  output logic             restart_o,
  output logic [CNT_W-1:0] ratio_o,
  output logic [CNT_W-1:0] high_o
);

  logic [1:0] sel_q;
  logic       sel_changed;

  always_ff @(posedge clk_i) begin
    sel_q <= sel_i;
  end

  assign sel_changed = (sel_i != sel_q);
  assign restart_o   = rst_i | sel_changed | is_reserved(sel_i);
  assign ratio_o     = ratio_of(sel_i);
  assign high_o      = high_of(ratio_o);

  // Outside a restart the selected ratio is one of the three legal values (R1)
  p_ratio_legal_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    !restart_o |-> (ratio_o >= CNT_W'(4) && ratio_o <= CNT_W'(6)));

endmodule

// File: rtl/ckd_phase_cnt.sv
module ckd_phase_cnt
  import ckd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] ratio_i,
  input  logic [CNT_W-1:0] high_i,
  output logic             phase_zero_o,
  output logic             prim_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             prim_q;
  logic             at_last;

  assign at_last = (cnt_q == ratio_i - CNT_W'(1));

  always_ff @(posedge clk_i) begin
    if (restart_i) begin
      cnt_q  <= '0;
      prim_q <= 1'b0;
    end else begin
      cnt_q  <= at_last ? '0 : cnt_q + CNT_W'(1);
      prim_q <= (cnt_q < high_i);
    end
  end

  assign phase_zero_o = !restart_i && (cnt_q == '0);
  assign prim_o       = prim_q;

  // Counter never leaves the window of the selected ratio (R1)
  p_cnt_in_window_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    !restart_i |-> (cnt_q < ratio_i));

  // A primary rising edge only ever starts a new period at phase zero (R7)
  p_prim_rise_at_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(prim_q) |-> ($past(cnt_q) == '0));

endmodule

// File: rtl/ckd_half_stage.sv
module ckd_half_stage (
  input  logic clk_i,
  input  logic rst_i,
  input  logic restart_i,
  input  logic phase_zero_i,
  output logic sec_o,
  output logic align_o
);

  logic sec_q;
  logic align_q;

  always_ff @(posedge clk_i) begin
    if (restart_i) begin
      sec_q   <= 1'b0;
      align_q <= 1'b0;
    end else begin
      sec_q   <= sec_q ^ phase_zero_i;
      align_q <= phase_zero_i & ~sec_q;
    end
  end

  assign sec_o   = sec_q;
  assign align_o = align_q;

  // Strobe lasts exactly one cycle (R6)
  p_align_one_cycle_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    align_q |=> !align_q);

  // Each secondary rising edge raises the strobe (R6)
  p_sec_rise_strobe_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sec_q) |-> align_q);

endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div
  import ckd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [1:0] sel_i,
  output logic       prim_o,
  output logic       sec_o,
  output logic       align_o
);

  logic             restart;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] high_len;
  logic             phase_zero;

  ckd_mode_ctl u_mode (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sel_i     (sel_i),
    .restart_o (restart),
    .ratio_o   (ratio),
    .high_o    (high_len)
  );

  ckd_phase_cnt u_phase (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .restart_i    (restart),
    .ratio_i      (ratio),
    .high_i       (high_len),
    .phase_zero_o (phase_zero),
    .prim_o       (prim_o)
  );

  ckd_half_stage u_half (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .restart_i    (restart),
    .phase_zero_i (phase_zero),
    .sec_o        (sec_o),
    .align_o      (align_o)
  );

  // Secondary rises only together with primary (R6)
  p_sec_with_prim_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sec_o) |-> $rose(prim_o));

  // Strobe only while both groups are high (R6)
  p_align_both_high_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    align_o |-> (prim_o && sec_o));

  // Reserved code holds everything low (R9)
  p_reserved_low_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    is_reserved(sel_i) |=> (!prim_o && !sec_o && !align_o));

  // A code change clears both groups (R8)
  p_change_clears_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_i != $past(sel_i)) |=> (!prim_o && !sec_o && !align_o));

endmodule

// File: tb/sim_clk_ratio_div.sv
module sim_clk_ratio_div;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] sel;
  logic       prim, sec, align;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  // driver-side model state
  logic [1:0] prev_sel = 2'b01;
  int         m = 0;

  always #5 clk = ~clk;

  clk_ratio_div u0 (
    .clk_i  (clk),
    .rst_i  (rst),
    .sel_i  (sel),
    .prim_o (prim),
    .sec_o  (sec),
    .align_o(align)
  );

  function automatic int ratio_for(input logic [1:0] c);
    case (c)
      2'b01:   return 4;
      2'b00:   return 5;
      2'b10:   return 6;
      default: return 0;
    endcase
  endfunction

  // One clock step: drive at the falling edge, queue the result expected after the next rising edge.
  task automatic step(input logic r, input logic [1:0] s);
    logic [2:0] e;
    string      t;
    int         n, k, hi;
    @(negedge clk);
    rst = r;
    sel = s;
    n = ratio_for(s);
    if (r) begin
      m = 0; e = 3'b000; t = "R7";
    end else if (s == 2'b11) begin
      m = 0; e = 3'b000; t = "R9";
    end else if (s != prev_sel) begin
      m = 0; e = 3'b000; t = "R8";
    end else begin
      m = m + 1;
      k  = (m - 1) % n;
      hi = (n == 5) ? 2 : n / 2;
      e[2] = (k < hi);
      e[1] = (((m - 1) / n) % 2) == 0;
      e[0] = ((m - 1) % (2 * n)) == 0;
      if (m == 1)      t = "R7";
      else if (n == 5) t = "R3";
      else             t = "R4";
    end
    prev_sel = s;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic run(input logic [1:0] s, input int cycles);
    for (int i = 0; i < cycles; i++) step(1'b0, s);
  endtask

  task automatic cmp(input logic act, input logic expv, input string req, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, expv, $time);
    end
  endtask

  // Monitor: pops one expected item per rising edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp(prim,  e[2], {t, "/R1"}, "prim_o");
      cmp(sec,   e[1], {t, "/R2/R5"}, "sec_o");
      cmp(align, e[0], {t, "/R6"}, "align_o");
    end
  end

  initial begin
    rst = 1'b1;
    sel = 2'b01;
    for (int i = 0; i < 3; i++) step(1'b1, 2'b01);   // R7 reset state
    run(2'b01, 40);                                  // R1 R4 div by 4
    run(2'b00, 60);                                  // R3 R8 div by 5
    run(2'b10, 60);                                  // R4 div by 6
    run(2'b11, 9);                                   // R9 reserved
    run(2'b00, 50);                                  // R9 exit, R5
    for (int i = 0; i < 2; i++) step(1'b1, 2'b10);   // R7 mid-run reset
    run(2'b10, 40);
    run(2'b01, 3);                                   // R8 fast changes
    run(2'b10, 2);
    run(2'b11, 1);
    run(2'b01, 30);
    step(1'b0, 2'b01);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule